// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of an accumulator-based 8-bit processor datapath. On each cycle it takes the accumulator value, a second operand and a 4-bit operation code. The second operand may come from a register, a memory byte or an immediate field. The block then produces three things: a result byte, a strobe that tells the datapath to write the result into the accumulator, and the next value of the five status flags. The stage itself is purely combinational. Only the flag set is held in a register inside the block.

The stored flags feed back into the stage in two ways. The carry-in and borrow variants read the stored carry. Operations that leave some flags untouched pass the stored values through. The sequencer raises a flag-enable strobe in the cycle whose flags should be kept, and the register captures the next flags on that clock edge. Step operations (increment and decrement) work on the second operand, so the datapath can route the stepped value to any destination. For that reason they never raise the accumulator write strobe.

Top module: `alu8_core`

## Requirements
- R1: The flag vector is {sign, zero, aux, parity, carry} from bit 4 down to bit 0. While rst_ni is low, flags_o is 0, and it clears at once when rst_ni falls.
- R2: On a rising clk_i edge with flag_en_i high, flags_o takes the value flags_nxt_o had before the edge. With flag_en_i low, flags_o holds its value.
- R3: Op 0 (add) gives res_o = acc_i + opnd_i, and op 1 (add with carry) also adds the stored carry. Carry is the carry out of bit 7, aux is the carry out of bit 3, and acc_we_o is 1.
- R4: Op 2 (subtract) gives res_o = acc_i - opnd_i, and op 3 (subtract with borrow) also subtracts the stored carry. Carry is set on a borrow out of bit 7, aux is set on a borrow out of bit 3, and acc_we_o is 1.
- R5: Op 7 (compare) sets all five flags exactly as op 2 would. It keeps acc_we_o at 0 and drives res_o = acc_i.
- R6: Op 4 (AND), op 5 (OR) and op 6 (XOR) write the bitwise result with acc_we_o = 1 and clear both carry and aux.
- R7: Op 8 gives res_o = opnd_i + 1 and op 9 gives res_o = opnd_i - 1, both with acc_we_o = 0. Aux reflects the nibble carry or borrow, and carry keeps its stored value.
- R8: Op 10 drives res_o = ~acc_i with acc_we_o = 1, and flags_nxt_o equals flags_o.
- R9: Op 11 inverts the stored carry and op 12 sets it to 1. Both leave the other four flags unchanged, drive acc_we_o = 0 and drive res_o = acc_i.
- R10: For ops 0 to 6, 8 and 9, the flags are set from res_o as follows: sign is res_o[7], zero is set when res_o is 0, and parity is set when res_o has an even number of ones.
- R11: Op codes 13 to 15 drive acc_we_o = 0 and res_o = acc_i, and they make flags_nxt_o equal flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the flag register |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand (register, memory byte or immediate) |
| op_i | input | 4 | Operation code |
| flag_en_i | input | 1 | Flag register load strobe |
| res_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Accumulator write enable |
| flags_nxt_o | output | 5 | Next flag vector {S,Z,A,P,C} |
| flags_o | output | 5 | Stored flag vector {S,Z,A,P,C} |

## Verification
Two functions meet in the same cycle: the stored carry is consumed as carry-in or borrow-in, and a new carry is produced that the flag strobe writes back over it. The bench first places a known carry in the register, using a zeroing compare followed, when needed, by a set-carry. It then issues the operation under test with the strobe high. The next flags are judged combinationally before the edge. The stored flags are judged after the edge, which confirms that the old carry was used and then replaced, rather than looped through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CMA  = 4'd10,
    OP_CMC  = 4'd11,
    OP_STC  = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } alu_op_e;

  // bit 4 down to bit 0
  typedef struct packed {
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          hcout_o
);
  localparam int NW = DW / 2;

  logic [DW-1:0] b_x;
  logic          c_x;
  logic [NW:0]   lo_sum;
  logic [DW:0]   full_sum;

  // subtract: a + ~b + ~borrow; carry outputs become borrows
  assign b_x = sub_i ? ~b_i : b_i;
  assign c_x = cin_i ^ sub_i;

  assign lo_sum   = {1'b0, a_i[NW-1:0]} + {1'b0, b_x[NW-1:0]} + {{NW{1'b0}}, c_x};
  assign full_sum = {1'b0, a_i} + {1'b0, b_x} + {{DW{1'b0}}, c_x};

  assign sum_o   = full_sum[DW-1:0];
  assign cout_o  = full_sum[DW] ^ sub_i;
  assign hcout_o = lo_sum[NW] ^ sub_i;
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    sel_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = a_i ^ b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     opnd_i,
  input  logic [3:0]        op_i,
  input  logic              flag_en_i,
  output logic [DW-1:0]     res_o,
  output logic              acc_we_o,
  output logic [FLAG_W-1:0] flags_nxt_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  alu_op_e           op;
  flags_t            fq;
  flags_t            fn;
  logic [FLAG_W-1:0] fq_v;

  logic [DW-1:0] as_a, as_b, as_sum, lg_y;
  logic          as_cin, as_sub, as_cout, as_hc;

  assign op = alu_op_e'(op_i);
  assign fq = flags_t'(fq_v);

  // operand steering for the shared adder
  always_comb begin
    as_a   = acc_i;
    as_b   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC:         as_cin = fq.c;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin
        as_sub = 1'b1;
        as_cin = fq.c;
      end
      OP_INC: begin
        as_a = opnd_i;
        as_b = ONE;
      end
      OP_DEC: begin
        as_a   = opnd_i;
        as_b   = ONE;
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .a_i    (as_a),
    .b_i    (as_b),
    .cin_i  (as_cin),
    .sub_i  (as_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .hcout_o(as_hc)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .sel_i(op_i[1:0]),
    .y_o  (lg_y)
  );

  // result, write strobe and next flags
  always_comb begin
    res_o    = acc_i;
    acc_we_o = 1'b0;
    fn       = fq;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_o    = as_sum;
        acc_we_o = 1'b1;
        fn.c     = as_cout;
        fn.a     = as_hc;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o    = lg_y;
        acc_we_o = 1'b1;
        fn.c     = 1'b0;
        fn.a     = 1'b0;
      end
      OP_CMP: begin
        fn.c = as_cout;
        fn.a = as_hc;
        fn.s = as_sum[DW-1];
        fn.z = ~|as_sum;
        fn.p = ~^as_sum;
      end
      OP_INC, OP_DEC: begin
        res_o = as_sum;
        fn.a  = as_hc;
      end
      OP_CMA: begin
        res_o    = ~acc_i;
        acc_we_o = 1'b1;
      end
      OP_CMC: fn.c = ~fq.c;
      OP_STC: fn.c = 1'b1;
      default: ;
    endcase
    if (op <= OP_DEC && op != OP_CMP) begin
      fn.s = res_o[DW-1];
      fn.z = ~|res_o;
      fn.p = ~^res_o;
    end
  end

  assign flags_nxt_o = fn;
  assign flags_o     = fq_v;

  alu8_flag_reg #(.W(FLAG_W)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (flag_en_i),
    .d_i   (fn),
    .q_o   (fq_v)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DW = 8,
  parameter int FW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    op_i,
  input logic          flag_en_i,
  input logic [DW-1:0] res_o,
  input logic          acc_we_o,
  input logic [FW-1:0] flags_nxt_o,
  input logic [FW-1:0] flags_o
);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i |=> flags_o == $past(flags_nxt_o));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_en_i |=> $stable(flags_o));

  a_r5_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd7 |-> !acc_we_o);

  a_r7_carry_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd8 || op_i == 4'd9) |-> (flags_nxt_o[0] == flags_o[0] && !acc_we_o));

  a_r8_cma_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd10 |-> (flags_nxt_o == flags_o && acc_we_o));

  a_r9_stc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 4'd12 |-> (flags_nxt_o[0] && flags_nxt_o[4:1] == flags_o[4:1]));

  a_r10_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i <= 4'd9 && op_i != 4'd7) |-> flags_nxt_o[3] == (res_o == '0));

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i >= 4'd13 |-> (!acc_we_o && flags_nxt_o == flags_o));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW), .FW(alu8_pkg::FLAG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .flag_en_i  (flag_en_i),
  .res_o      (res_o),
  .acc_we_o   (acc_we_o),
  .flags_nxt_o(flags_nxt_o),
  .flags_o    (flags_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic [3:0] op_i = 4'd13;
  logic       flag_en_i = 1'b0;
  logic [7:0] res_o;
  logic       acc_we_o;
  logic [4:0] flags_nxt_o;
  logic [4:0] flags_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  alu8_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .opnd_i(opnd_i),
    .op_i(op_i), .flag_en_i(flag_en_i), .res_o(res_o), .acc_we_o(acc_we_o),
    .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] acc;
    logic [7:0] opnd;
    logic       cin;
    logic [7:0] res;
    logic       we;
    logic [4:0] fl;
  } vec_t;

  // flags {S,Z,A,P,C}; prior flags are 01010 (cin=0) or 01011 (cin=1)
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  8'h3A, 8'hC6, 1'b0, 8'h00, 1'b1, 5'b01111},
    '{4'd1,  8'h0F, 8'h01, 1'b1, 8'h11, 1'b1, 5'b00110},
    '{4'd0,  8'h7F, 8'h01, 1'b1, 8'h80, 1'b1, 5'b10100},
    '{4'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 1'b1, 5'b10101},
    '{4'd3,  8'h10, 8'h0F, 1'b1, 8'h00, 1'b1, 5'b01110},
    '{4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 5'b10111},
    '{4'd7,  8'h42, 8'h42, 1'b1, 8'h42, 1'b0, 5'b01010},
    '{4'd7,  8'h10, 8'h20, 1'b0, 8'h10, 1'b0, 5'b10011},
    '{4'd4,  8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 5'b00010},
    '{4'd5,  8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 5'b01010},
    '{4'd6,  8'hFF, 8'h01, 1'b0, 8'hFE, 1'b1, 5'b10000},
    '{4'd8,  8'h55, 8'hFF, 1'b1, 8'h00, 1'b0, 5'b01111},
    '{4'd8,  8'h55, 8'h7F, 1'b0, 8'h80, 1'b0, 5'b10100},
    '{4'd9,  8'h55, 8'h00, 1'b0, 8'hFF, 1'b0, 5'b10110},
    '{4'd9,  8'h55, 8'h10, 1'b1, 8'h0F, 1'b0, 5'b00111},
    '{4'd10, 8'h5A, 8'h00, 1'b1, 8'hA5, 1'b1, 5'b01011},
    '{4'd11, 8'h12, 8'h00, 1'b1, 8'h12, 1'b0, 5'b01010},
    '{4'd11, 8'h12, 8'h00, 1'b0, 8'h12, 1'b0, 5'b01011},
    '{4'd12, 8'h34, 8'h00, 1'b0, 8'h34, 1'b0, 5'b01011},
    '{4'd13, 8'h99, 8'h00, 1'b1, 8'h99, 1'b0, 5'b01011}
  };

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R3";
      4'd2, 4'd3:       return "R4";
      4'd7:             return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd8, 4'd9:       return "R7";
      4'd10:            return "R8";
      4'd11, 4'd12:     return "R9";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // load flags 01010 via compare of zeros, then optionally set carry
  task automatic preset(logic cin);
    @(negedge clk_i);
    op_i = 4'd7; acc_i = 8'h00; opnd_i = 8'h00; flag_en_i = 1'b1;
    if (cin) begin
      @(negedge clk_i);
      op_i = 4'd12;
    end
    @(negedge clk_i);
    flag_en_i = 1'b0;
  endtask

  initial begin
    #5;
    check("R1", "flags in reset", 32'(flags_o), 32'h0);
    #40;
    rst_ni = 1'b1;

    foreach (VEC[i]) begin
      preset(VEC[i].cin);
      op_i = VEC[i].op; acc_i = VEC[i].acc; opnd_i = VEC[i].opnd; flag_en_i = 1'b1;
      #2;
      check(req_of(VEC[i].op), "res", 32'(res_o), 32'(VEC[i].res));
      check(req_of(VEC[i].op), "we", 32'(acc_we_o), 32'(VEC[i].we));
      check({req_of(VEC[i].op), ",R10"}, "flags_nxt", 32'(flags_nxt_o), 32'(VEC[i].fl));
      @(negedge clk_i);
      check("R2", "flags after load", 32'(flags_o), 32'(VEC[i].fl));
      flag_en_i = 1'b0;
    end

    // strobe low: stored flags must not move
    preset(1'b1);
    op_i = 4'd0; acc_i = 8'h3A; opnd_i = 8'hC6; flag_en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R2", "hold without strobe", 32'(flags_o), 32'b01011);

    // chained carry: STC then ADC consumes it and writes a new one
    preset(1'b1);
    op_i = 4'd1; acc_i = 8'hFF; opnd_i = 8'h00; flag_en_i = 1'b1;
    #2;
    check("R3", "adc 0xFF+0+1 res", 32'(res_o), 32'h00);
    @(negedge clk_i);
    check("R3", "adc new flags", 32'(flags_o), 32'b01111);
    #2;
    check("R3", "adc reuse carry res", 32'(res_o), 32'h00);
    flag_en_i = 1'b0;

    // asynchronous reset mid-run
    preset(1'b1);
    #3;
    rst_ni = 1'b0;
    #1;
    check("R1", "async clear", 32'(flags_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule